// File: doc/BRIEF.md
# Host Bus Palette and Register Port

This block lets a host processor reach a 256-entry color lookup memory, with 30 bits per entry, and a small set of control registers over a narrow strobed bus. A transfer is framed by an active-low enable. The command select and direction inputs are captured when the enable falls. Write data is taken when it rises. While a read is in progress the block drives read data. The bus strobes are sampled by the block clock, so each enable phase must last at least two clock periods.

Palette entries are moved as a red, green, blue sequence through one shared step counter. After blue the entry address advances by one. A mode bit picks how each color crosses the bus. In the 10-bit path one transfer carries a whole color. In the byte path two transfers carry it: first the upper eight bits, then the lowest two. The register file holds the pixel mask, the transfer mode bit and a general control word. The mask and the control word are outputs for the pixel path.

The chip-level pad drives the shared data lines from a separate read-data port and output enable. Inside the block these are kept as three plain ports.

Top module: `host_pal_port`

## Requirements
- R1: The command select (`cmd`) and direction (`rw`) are captured in the first clock after `cs_n` falls. Changing them later in the same enable pulse has no effect on the transfer.
- R2: Write data is taken from `bus_wdata` in the clock in which `cs_n` is first seen high again. Values present earlier in the pulse are not used.
- R3: `bus_rd_oe` is low whenever `cs_n` is high and during write transfers. It is high from the clock after the enable falls until the enable rises, but only for reads. `bus_rdata` is zero whenever `bus_rd_oe` is low.
- R4: Command 00 addresses the entry address register. A write loads `bus_wdata[7:0]` and restarts the color sequence at red with the upper byte half. A read returns the address in bits 7:0, with bits 9:8 zero.
- R5: Command 01 in 10-bit mode moves one color per transfer in the order red, green, blue. The third write stores all three colors into the entry at the current address in one step, and the address then advances by one.
- R6: In byte mode (mode bit set) each color takes two transfers. The first carries the color's bits 9:2 in `bus_wdata[7:0]`. The second carries bits 1:0 in `bus_wdata[1:0]`. All other data bits are ignored.
- R7: Palette reads in 10-bit mode return red, green, then blue of the entry at the current address. They use the same step counter as writes, and the address advances by one after blue.
- R8: Palette reads in byte mode return `{2'b00, color[9:2]}` and then `{8'b0, color[1:0]}` for each color in turn.
- R9: The entry address wraps from 255 to 0 on advance.
- R10: Command 10 accesses the register selected by the entry address. Index 0 is the pixel mask (bits 7:0, output `pix_mask`). Index 1 is the mode (bit 0 set selects byte mode). Index 2 is the general control word (10 bits, output `gen_ctrl`). Other indexes read as zero and ignore writes. Register access does not change the address.
- R11: Command 11 is reserved. Its writes change nothing and its reads return zero.
- R12: After reset the address is 0, the mask is 0xFF, the mode is 10-bit, `gen_ctrl` is 0 and `bus_rd_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low transfer enable |
| rw | input | 1 | 1 = read, 0 = write |
| cmd | input | 2 | Command select: 00 address, 01 palette, 10 register, 11 reserved |
| bus_wdata | input | 10 | Data from host |
| bus_rdata | output | 10 | Data to host |
| bus_rd_oe | output | 1 | Pad drive enable for read data |
| pix_mask | output | 8 | Pixel mask register |
| gen_ctrl | output | 10 | General control register |

## Verification
A blue-phase palette write stores the entry and advances the address in the same clock. At entry 255 that advance also wraps the address to 0. The bench writes entry 255 and then entry 0. It reloads the address to 255 and reads six colors across the wrap, and it reads the address register after each write group. Every write and read also changes the command, direction and data inputs between the enable edges. The scoreboard would then catch a block that samples them at the wrong edge.

// File: rtl/host_pal_pkg.sv
package host_pal_pkg;
  typedef enum logic [1:0] {
    CMD_ADDR = 2'b00,
    CMD_PAL  = 2'b01,
    CMD_CTL  = 2'b10,
    CMD_RSVD = 2'b11
  } bus_cmd_e;

  localparam int unsigned N_COLORS = 3;
endpackage

// File: rtl/bus_edge_sampler.sv
module bus_edge_sampler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rw,
  input  logic [1:0] cmd,
  output logic       active,
  output logic       rw_q,
  output logic [1:0] cmd_q,
  output logic       wr_stb,
  output logic       rd_stb
);
  logic cs_q, active_d, rw_d;
  logic [1:0] cmd_d;
  logic fall, rise;

  assign fall = cs_q & ~cs_n;
  assign rise = ~cs_q & cs_n & active;

  always_comb begin
    active_d = active;
    rw_d     = rw_q;
    cmd_d    = cmd_q;
    if (fall) begin
      active_d = 1'b1;
      rw_d     = rw;
      cmd_d    = cmd;
    end else if (rise) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      active <= 1'b0;
      rw_q   <= 1'b1;
      cmd_q  <= 2'b00;
    end else begin
      cs_q   <= cs_n;
      active <= active_d;
      rw_q   <= rw_d;
      cmd_q  <= cmd_d;
    end
  end

  assign wr_stb = rise & ~rw_q;
  assign rd_stb = rise & rw_q;

  // R1
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cs_n) |=> ($stable(cmd_q) && $stable(rw_q)));
endmodule

// File: rtl/pal_sequencer.sv
module pal_sequencer #(
  parameter int DW = 10,
  parameter int AW = 8,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adr_ld,
  input  logic [AW-1:0] adr_din,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic          byte_mode,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;
  localparam int EW    = host_pal_pkg::N_COLORS * DW;
  localparam int LW    = DW - BW;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_d;
  logic [1:0]    phase_q, phase_d;
  logic          sub_q, sub_d;
  logic [DW-1:0] hold_r, hold_g, cval, cur;
  logic [BW-1:0] hold_msb;
  logic          step, last_half, color_done;

  assign step       = wr_stb | rd_stb;
  assign last_half  = ~byte_mode | sub_q;
  assign color_done = step & last_half & ~adr_ld;
  assign cval       = byte_mode ? {hold_msb, wdata[LW-1:0]} : wdata;

  always_comb begin
    addr_d  = addr_q;
    phase_d = phase_q;
    sub_d   = sub_q;
    if (adr_ld) begin
      addr_d  = adr_din;
      phase_d = 2'd0;
      sub_d   = 1'b0;
    end else if (step) begin
      if (byte_mode && !sub_q) begin
        sub_d = 1'b1;
      end else begin
        sub_d = 1'b0;
        if (phase_q == 2'd2) begin
          phase_d = 2'd0;
          addr_d  = addr_q + {{(AW-1){1'b0}}, 1'b1};
        end else begin
          phase_d = phase_q + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      phase_q <= 2'd0;
      sub_q   <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      phase_q <= phase_d;
      sub_q   <= sub_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_r   <= '0;
      hold_g   <= '0;
      hold_msb <= '0;
    end else begin
      if (wr_stb && byte_mode && !sub_q) hold_msb <= wdata[BW-1:0];
      if (wr_stb && color_done && phase_q == 2'd0) hold_r <= cval;
      if (wr_stb && color_done && phase_q == 2'd1) hold_g <= cval;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_stb && color_done && phase_q == 2'd2) mem[addr_q] <= {hold_r, hold_g, cval};
  end

  always_comb begin
    case (phase_q)
      2'd0:    cur = mem[addr_q][EW-1 -: DW];
      2'd1:    cur = mem[addr_q][2*DW-1 -: DW];
      default: cur = mem[addr_q][DW-1:0];
    endcase
    if (!byte_mode)  rd_word = cur;
    else if (!sub_q) rd_word = {{LW{1'b0}}, cur[DW-1:LW]};
    else             rd_word = {{BW{1'b0}}, cur[LW-1:0]};
  end

  // R5
  entry_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (color_done && phase_q == 2'd2) |=> (addr_q == $past(addr_q) + 1'b1));
  // R4
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adr_ld |=> (phase_q == 2'd0 && !sub_q && addr_q == $past(adr_din)));
  // R6
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
  parameter int DW = 10,
  parameter int AW = 8,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [MW-1:0] mask_q,
  output logic          byte_mode,
  output logic [DW-1:0] gctl_q,
  output logic [DW-1:0] rdata
);
  logic mask_en, mode_en, gctl_en;

  assign mask_en = wr_en && (idx == AW'(0));
  assign mode_en = wr_en && (idx == AW'(1));
  assign gctl_en = wr_en && (idx == AW'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      byte_mode <= 1'b0;
      gctl_q    <= '0;
    end else begin
      if (mask_en) mask_q    <= wdata[MW-1:0];
      if (mode_en) byte_mode <= wdata[0];
      if (gctl_en) gctl_q    <= wdata;
    end
  end

  always_comb begin
    case (idx)
      AW'(0):  rdata = {{(DW-MW){1'b0}}, mask_q};
      AW'(1):  rdata = {{(DW-1){1'b0}}, byte_mode};
      AW'(2):  rdata = gctl_q;
      default: rdata = '0;
    endcase
  end

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_en |=> $stable(mask_q));
endmodule

// File: rtl/host_pal_port.sv
module host_pal_port #(
  parameter int DW = 10,
  parameter int AW = 8,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rw,
  input  logic [1:0]    cmd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rd_oe,
  output logic [BW-1:0] pix_mask,
  output logic [DW-1:0] gen_ctrl
);
  import host_pal_pkg::*;

  logic          rst_s1, rst_sn;
  logic          active, rw_q, wr_stb, rd_stb, byte_mode;
  logic [1:0]    cmd_q;
  logic [AW-1:0] addr;
  logic [DW-1:0] pal_word, ctl_word, sel_word;
  bus_cmd_e      op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  bus_edge_sampler u_smp (
    .clk(clk), .rst_n(rst_sn), .cs_n(cs_n), .rw(rw), .cmd(cmd),
    .active(active), .rw_q(rw_q), .cmd_q(cmd_q), .wr_stb(wr_stb), .rd_stb(rd_stb)
  );

  assign op = bus_cmd_e'(cmd_q);

  pal_sequencer #(.DW(DW), .AW(AW), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_sn),
    .adr_ld(wr_stb && op == CMD_ADDR), .adr_din(bus_wdata[AW-1:0]),
    .wr_stb(wr_stb && op == CMD_PAL), .rd_stb(rd_stb && op == CMD_PAL),
    .byte_mode(byte_mode), .wdata(bus_wdata),
    .addr_q(addr), .rd_word(pal_word)
  );

  ctl_regfile #(.DW(DW), .AW(AW), .MW(BW)) u_ctl (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_stb && op == CMD_CTL),
    .idx(addr), .wdata(bus_wdata), .mask_q(pix_mask), .byte_mode(byte_mode),
    .gctl_q(gen_ctrl), .rdata(ctl_word)
  );

  always_comb begin
    case (op)
      CMD_ADDR: sel_word = {{(DW-AW){1'b0}}, addr};
      CMD_PAL:  sel_word = pal_word;
      CMD_CTL:  sel_word = ctl_word;
      default:  sel_word = '0;
    endcase
  end

  assign bus_rd_oe = ~cs_n & active & rw_q;
  assign bus_rdata = bus_rd_oe ? sel_word : '0;

  // R3
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (active && !rw_q) |-> !bus_rd_oe);
  // R11
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_stb && op == CMD_RSVD) |=> ($stable(addr) && $stable(pix_mask) && $stable(gen_ctrl)));
endmodule

// File: tb/test_host_pal_port.sv
module test_host_pal_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       rw = 1'b1;
  logic [1:0] cmd = 2'b00;
  logic [9:0] bus_wdata = '0;
  logic [9:0] bus_rdata;
  logic       bus_rd_oe;
  logic [7:0] pix_mask;
  logic [9:0] gen_ctrl;

  int total = 0;
  int bad = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic       prev_oe = 1'b0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_pal_port i_host_pal_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .cmd(cmd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd_oe(bus_rd_oe),
    .pix_mask(pix_mask), .gen_ctrl(gen_ctrl)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write: cmd/rw/data are disturbed inside the pulse (R1, R2)
  task automatic bus_wr(input logic [1:0] c, input logic [9:0] d);
    @(negedge clk); cmd = c; rw = 1'b0; bus_wdata = 10'h2D2; cs_n = 1'b0;
    @(negedge clk); check("R3 oe during write", {9'b0, bus_rd_oe}, 10'h0);
    @(negedge clk); cmd = ~c; rw = 1'b1; bus_wdata = d;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); bus_wdata = 10'h155;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] c, input logic [9:0] exp, input string req);
    @(negedge clk); cmd = c; rw = 1'b1; cs_n = 1'b0;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    @(negedge clk); cmd = ~c; rw = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: scoreboard pop on the first driven cycle of each read
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (bus_rd_oe && !prev_oe) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R3 unexpected drive actual=%h expected=none", bus_rdata);
        end else begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
      if (cs_n && bus_rd_oe) begin
        total++; bad++;
        $display("FAIL R3 drive while idle actual=1 expected=0");
      end
      if (!bus_rd_oe && bus_rdata != 10'h0) begin
        total++; bad++;
        $display("FAIL R3 rdata undriven actual=%h expected=000", bus_rdata);
      end
      prev_oe <= bus_rd_oe;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    check("R12 oe", {9'b0, bus_rd_oe}, 10'h0);
    check("R12 mask", {2'b0, pix_mask}, 10'h0FF);
    check("R12 gen_ctrl", gen_ctrl, 10'h000);
    bus_rd(2'b00, 10'h000, "R12 addr reset");

    // R4 address load and readback
    bus_wr(2'b00, 10'h310);
    bus_rd(2'b00, 10'h010, "R4 addr read");
    // R5 10-bit entry write
    bus_wr(2'b01, 10'h3A5);
    bus_wr(2'b01, 10'h0C3);
    bus_wr(2'b01, 10'h2F0);
    bus_rd(2'b00, 10'h011, "R5 addr advance");
    // R7 10-bit readback
    bus_wr(2'b00, 10'h010);
    bus_rd(2'b01, 10'h3A5, "R7 red");
    bus_rd(2'b01, 10'h0C3, "R7 green");
    bus_rd(2'b01, 10'h2F0, "R7 blue");
    bus_rd(2'b00, 10'h011, "R7 addr advance");
    // R1: cmd flipped to 11 mid pulse still loads the address
    bus_wr(2'b00, 10'h020);
    bus_rd(2'b00, 10'h020, "R1 cmd captured at fall");

    // R9 wrap: entry 255 commit and address wrap in one cycle
    bus_wr(2'b00, 10'h0FF);
    bus_wr(2'b01, 10'h155);
    bus_wr(2'b01, 10'h2AA);
    bus_wr(2'b01, 10'h3FF);
    bus_rd(2'b00, 10'h000, "R9 addr wrap");
    bus_wr(2'b01, 10'h001);
    bus_wr(2'b01, 10'h002);
    bus_wr(2'b01, 10'h003);
    bus_wr(2'b00, 10'h0FF);
    bus_rd(2'b01, 10'h155, "R9 e255 red");
    bus_rd(2'b01, 10'h2AA, "R9 e255 green");
    bus_rd(2'b01, 10'h3FF, "R9 e255 blue");
    bus_rd(2'b01, 10'h001, "R9 e0 red");
    bus_rd(2'b01, 10'h002, "R9 e0 green");
    bus_rd(2'b01, 10'h003, "R9 e0 blue");
    bus_rd(2'b00, 10'h001, "R9 addr after wrap");

    // R10 register file
    bus_wr(2'b00, 10'h000);
    bus_wr(2'b10, 10'h35A);
    check("R10 mask out", {2'b0, pix_mask}, 10'h05A);
    bus_rd(2'b10, 10'h05A, "R10 mask read");
    bus_rd(2'b00, 10'h000, "R10 addr unchanged");
    bus_wr(2'b00, 10'h002);
    bus_wr(2'b10, 10'h2C7);
    check("R10 gen_ctrl out", gen_ctrl, 10'h2C7);
    bus_wr(2'b00, 10'h007);
    bus_wr(2'b10, 10'h3FF);
    bus_rd(2'b10, 10'h000, "R10 unused index");
    check("R10 mask kept", {2'b0, pix_mask}, 10'h05A);
    check("R10 gen_ctrl kept", gen_ctrl, 10'h2C7);

    // R11 reserved command
    bus_wr(2'b11, 10'h3FF);
    bus_rd(2'b11, 10'h000, "R11 reserved read");
    bus_rd(2'b00, 10'h007, "R11 addr kept");
    check("R11 mask kept", {2'b0, pix_mask}, 10'h05A);
    check("R11 gen_ctrl kept", gen_ctrl, 10'h2C7);

    // R6 byte-mode write (mode index 1, bit 0)
    bus_wr(2'b00, 10'h001);
    bus_wr(2'b10, 10'h001);
    bus_rd(2'b10, 10'h001, "R10 mode read");
    bus_wr(2'b00, 10'h040);
    bus_wr(2'b01, 10'h3AD);
    bus_wr(2'b01, 10'h2A3);
    bus_wr(2'b01, 10'h000);
    bus_wr(2'b01, 10'h3FD);
    bus_wr(2'b01, 10'h0FF);
    bus_wr(2'b01, 10'h00E);
    bus_rd(2'b00, 10'h041, "R6 addr advance");
    // R8 byte-mode read
    bus_wr(2'b00, 10'h040);
    bus_rd(2'b01, 10'h0AD, "R8 red msb");
    bus_rd(2'b01, 10'h003, "R8 red lsb");
    bus_rd(2'b01, 10'h000, "R8 green msb");
    bus_rd(2'b01, 10'h001, "R8 green lsb");
    bus_rd(2'b01, 10'h0FF, "R8 blue msb");
    bus_rd(2'b01, 10'h002, "R8 blue lsb");
    bus_wr(2'b00, 10'h010);
    bus_rd(2'b01, 10'h0E9, "R8 e16 red msb");
    bus_rd(2'b01, 10'h001, "R8 e16 red lsb");
    // back to 10-bit, R6 entry read whole
    bus_wr(2'b00, 10'h001);
    bus_wr(2'b10, 10'h000);
    bus_wr(2'b00, 10'h040);
    bus_rd(2'b01, 10'h2B7, "R6 red");
    bus_rd(2'b01, 10'h001, "R6 green");
    bus_rd(2'b01, 10'h3FE, "R6 blue");
    // R2: data held only at the rise is what lands
    bus_wr(2'b00, 10'h033);
    bus_rd(2'b00, 10'h033, "R2 data at rise");

    repeat (3) @(negedge clk);
    done = 1'b1;
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R3 reads not seen actual=%0d expected=0", exp_q.size());
    end
    check("R3 idle oe", {9'b0, bus_rd_oe}, 10'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule